// File: doc/BRIEF.md
# Bridge Interrupt Status and Lock Register

This block holds the small set of control and status registers that a bus bridge keeps beside its datapath. Single-cycle event pulses from the rest of the bridge land in two sticky status registers. The first is an 8-bit local status register, which has a companion mask register. The second is a 4-bit error field that sits in the top nibble of a 16-bit error status word. The block raises one level-sensitive interrupt whenever a local status bit is set and its mask bit is also set.

A guarded system control register carries two bits: a lock flag and a release bit that drives the downstream bus reset. While the lock flag is set, the only write that has any effect is the 16-bit unlock key, and that write clears the lock. Once the register is unlocked, ordinary writes set both bits directly, and software normally sets the lock again when it has finished.

Software reaches all four registers through one flat port. The port has an enable, a write flag, a 2-bit register select and 16-bit data in each direction. Register select 0 is local status, 1 is the mask, 2 is error status and 3 is system control.

Top module: `brg_irq_ctl`

## Requirements
- R1: After reset, local status, mask and error status all read 0. System control reads 0x4000 (lock bit 14 set, release bit 15 clear). `irq_o` is low and `down_rst_n` is low.
- R2: A pulse on `loc_evt[i]` sets local status bit i, and the bit stays set until it is cleared. The bit meanings are 0 DMA channel 0, 1 DMA channel 1, 2 inbound queue write, 3 parity error, 4 pin interrupt, 5 write abort, 6 read abort and 7 mailbox. Local status is read at select 0 in bits 7:0, and bits 15:8 read 0.
- R3: Any write to select 0 clears all eight local status bits, whatever the write data is.
- R4: An event pulse that arrives in the same cycle as a clear of its register wins, so its bit stays set. This holds for both the local status register and the error status register.
- R5: The mask register is read and written at select 0b01 in bits 7:0. `irq_o` is high exactly when some local status bit and the same mask bit are both 1.
- R6: The error pulses set error status bits as follows: `err_evt[3]` (parity) sets bit 15, `err_evt[2]` (system error) sets bit 14, `err_evt[1]` (master abort) sets bit 13 and `err_evt[0]` (target abort) sets bit 12. Bits 11:0 read 0.
- R7: Writing select 2 clears each error bit in 15:12 that is written as 1 and leaves the bits written as 0 unchanged. Writing back the value that was read clears exactly the bits that were set.
- R8: While the register is locked, a write of 0xA05F to select 3 clears the lock and leaves the release bit unchanged. The key value written to any other select does not unlock.
- R9: While the register is locked, every other write to select 3 is ignored.
- R10: While the register is unlocked, a write to select 3 loads the release bit from data bit 15 and the lock bit from data bit 14. `down_rst_n` follows the release bit.
- R11: Error status has no effect on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access enable |
| reg_we | input | 1 | 1 = write, 0 = read (when `reg_en` is 1) |
| reg_addr | input | 2 | Register select: 0 local status, 1 mask, 2 error status, 3 system |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (0 when no read is enabled) |
| loc_evt | input | 8 | Local event pulses, one per status bit |
| err_evt | input | 4 | Error event pulses: 3 parity, 2 system, 1 master abort, 0 target abort |
| irq_o | output | 1 | Level interrupt from unmasked local status |
| down_rst_n | output | 1 | Downstream bus reset, active low (release bit) |

## Verification
Every register is updated on the clock edge that samples its write or event pulse. `irq_o` and `down_rst_n` are decoded directly from those registers, so they change at that same edge. Read data is a combinational view of the selected register, so a read issued after that edge already shows the new value with no further clock. The bench therefore drives each stimulus for exactly one edge and samples 1 ns after that edge. It reads registers 1 ns after setting the select, without waiting for another edge. Same-cycle races are tested by asserting the event pulse and the clearing write together for that single edge.

// File: rtl/brg_irq_pkg.sv
package brg_irq_pkg;

    localparam int BUS_W      = 16;
    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_LSTAT = 2'd0,
        SEL_LMASK = 2'd1,
        SEL_ERR   = 2'd2,
        SEL_SYS   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CLR_ON_ANY_WRITE = 1'b0,
        CLR_ON_ONE       = 1'b1
    } clr_mode_e;

    typedef struct packed {
        logic lstat;
        logic lmask;
        logic err;
        logic sys;
    } wr_strobe_t;

    typedef struct packed {
        logic rel;
        logic locked;
    } sys_state_t;

    localparam sys_state_t SYS_RESET = '{rel: 1'b0, locked: 1'b1};

    function automatic logic [BUS_W-1:0] sys_view(input sys_state_t s);
        logic [BUS_W-1:0] v;
        v = '0;
        v[BUS_W-1] = s.rel;
        v[BUS_W-2] = s.locked;
        return v;
    endfunction

endpackage

// File: rtl/brg_sticky_bits.sv
module brg_sticky_bits
    import brg_irq_pkg::*;
#(
    parameter int        W    = 8,
    parameter clr_mode_e MODE = CLR_ON_ANY_WRITE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_stb_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] stat_o
);

    logic [W-1:0] clr_vec;
    logic [W-1:0] stat_q;

    generate
        if (MODE == CLR_ON_ANY_WRITE) begin : g_clr_all
            logic unused_clr_data;
            assign unused_clr_data = ^clr_data_i;
            assign clr_vec = {W{clr_stb_i}};
        end else begin : g_clr_w1c
            assign clr_vec = clr_stb_i ? clr_data_i : '0;
        end
    endgenerate

    // A set pulse is applied after the clear, so it wins a same-cycle race.
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | set_i;
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/brg_sys_guard.sv
module brg_sys_guard
    import brg_irq_pkg::*;
#(
    parameter int         W   = 16,
    parameter logic [W-1:0] KEY = 16'hA05F
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output sys_state_t   state_o
);

    sys_state_t st_q;
    sys_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            if (st_q.locked) begin
                if (wdata_i == KEY) begin
                    st_d.locked = 1'b0;
                end
            end else begin
                st_d.rel    = wdata_i[W-1];
                st_d.locked = wdata_i[W-2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SYS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/brg_reg_access.sv
module brg_reg_access
    import brg_irq_pkg::*;
#(
    parameter int LOC_W = 8,
    parameter int ERR_W = 4
) (
    input  logic                  reg_en,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [LOC_W-1:0]      loc_stat_i,
    input  logic [LOC_W-1:0]      loc_mask_i,
    input  logic [ERR_W-1:0]      err_stat_i,
    input  sys_state_t            sys_i,
    output wr_strobe_t            wstb_o,
    output logic [BUS_W-1:0]      rdata_o
);

    localparam int LOC_PAD = BUS_W - LOC_W;
    localparam int ERR_PAD = BUS_W - ERR_W;

    reg_sel_e         sel;
    logic [BUS_W-1:0] view_loc;
    logic [BUS_W-1:0] view_mask;
    logic [BUS_W-1:0] view_err;

    assign sel       = reg_sel_e'(reg_addr);
    assign view_loc  = {{LOC_PAD{1'b0}}, loc_stat_i};
    assign view_mask = {{LOC_PAD{1'b0}}, loc_mask_i};
    assign view_err  = {err_stat_i, {ERR_PAD{1'b0}}};

    always_comb begin
        wstb_o = '0;
        if (reg_en && reg_we) begin
            unique case (sel)
                SEL_LSTAT: wstb_o.lstat = 1'b1;
                SEL_LMASK: wstb_o.lmask = 1'b1;
                SEL_ERR:   wstb_o.err   = 1'b1;
                SEL_SYS:   wstb_o.sys   = 1'b1;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        if (reg_en && !reg_we) begin
            unique case (sel)
                SEL_LSTAT: rdata_o = view_loc;
                SEL_LMASK: rdata_o = view_mask;
                SEL_ERR:   rdata_o = view_err;
                SEL_SYS:   rdata_o = sys_view(sys_i);
            endcase
        end
    end

endmodule

// File: rtl/brg_irq_ctl.sv
module brg_irq_ctl
    import brg_irq_pkg::*;
#(
    parameter int               LOC_W      = 8,
    parameter int               ERR_W      = 4,
    parameter logic [BUS_W-1:0] UNLOCK_KEY = 16'hA05F
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_en,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]      reg_wdata,
    output logic [BUS_W-1:0]      reg_rdata,
    input  logic [LOC_W-1:0]      loc_evt,
    input  logic [ERR_W-1:0]      err_evt,
    output logic                  irq_o,
    output logic                  down_rst_n
);

    wr_strobe_t       wstb;
    logic [LOC_W-1:0] loc_stat;
    logic [LOC_W-1:0] loc_mask;
    logic [ERR_W-1:0] err_stat;
    sys_state_t       sys_q;

    brg_reg_access #(
        .LOC_W (LOC_W),
        .ERR_W (ERR_W)
    ) u_acc (
        .reg_en     (reg_en),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .loc_stat_i (loc_stat),
        .loc_mask_i (loc_mask),
        .err_stat_i (err_stat),
        .sys_i      (sys_q),
        .wstb_o     (wstb),
        .rdata_o    (reg_rdata)
    );

    brg_sticky_bits #(
        .W    (LOC_W),
        .MODE (CLR_ON_ANY_WRITE)
    ) u_loc (
        .clk        (clk),
        .rst        (rst),
        .set_i      (loc_evt),
        .clr_stb_i  (wstb.lstat),
        .clr_data_i (reg_wdata[LOC_W-1:0]),
        .stat_o     (loc_stat)
    );

    brg_sticky_bits #(
        .W    (ERR_W),
        .MODE (CLR_ON_ONE)
    ) u_err (
        .clk        (clk),
        .rst        (rst),
        .set_i      (err_evt),
        .clr_stb_i  (wstb.err),
        .clr_data_i (reg_wdata[BUS_W-1 -: ERR_W]),
        .stat_o     (err_stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_mask <= '0;
        end else if (wstb.lmask) begin
            loc_mask <= reg_wdata[LOC_W-1:0];
        end
    end

    brg_sys_guard #(
        .W   (BUS_W),
        .KEY (UNLOCK_KEY)
    ) u_sys (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wstb.sys),
        .wdata_i (reg_wdata),
        .state_o (sys_q)
    );

    assign irq_o      = |(loc_stat & loc_mask);
    assign down_rst_n = sys_q.rel;

endmodule

// File: rtl/brg_irq_ctl_chk.sv
module brg_irq_ctl_chk
    import brg_irq_pkg::*;
#(
    parameter int               LOC_W = 8,
    parameter int               ERR_W = 4,
    parameter logic [BUS_W-1:0] KEY   = 16'hA05F
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_en,
    input logic                  reg_we,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [BUS_W-1:0]      reg_wdata,
    input logic [LOC_W-1:0]      loc_evt,
    input logic [ERR_W-1:0]      err_evt,
    input logic [LOC_W-1:0]      loc_stat,
    input logic [LOC_W-1:0]      loc_mask,
    input logic [ERR_W-1:0]      err_stat,
    input logic                  sys_rel,
    input logic                  sys_locked,
    input logic                  irq_o
);

    logic wr_loc;
    logic wr_err;
    logic wr_sys;

    assign wr_loc = reg_en && reg_we && (reg_addr == SEL_LSTAT);
    assign wr_err = reg_en && reg_we && (reg_addr == SEL_ERR);
    assign wr_sys = reg_en && reg_we && (reg_addr == SEL_SYS);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sys_locked && !sys_rel && loc_stat == '0 &&
                        loc_mask == '0 && err_stat == '0));

    a_r3_write_clears_all: assert property (@(posedge clk) disable iff (rst)
        (wr_loc && loc_evt == '0) |=> (loc_stat == '0));

    a_r4_loc_set_wins: assert property (@(posedge clk) disable iff (rst)
        (loc_evt != '0) |=> ((loc_stat & $past(loc_evt)) == $past(loc_evt)));

    a_r4_err_set_wins: assert property (@(posedge clk) disable iff (rst)
        (err_evt != '0) |=> ((err_stat & $past(err_evt)) == $past(err_evt)));

    a_r5_no_mask_no_irq: assert property (@(posedge clk) disable iff (rst)
        (loc_mask == '0) |-> !irq_o);

    a_r7_one_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_err && err_evt == '0) |=>
            (err_stat == ($past(err_stat) & ~$past(reg_wdata[BUS_W-1 -: ERR_W]))));

    a_r8_key_unlocks: assert property (@(posedge clk) disable iff (rst)
        (sys_locked && wr_sys && reg_wdata == KEY) |=> (!sys_locked && $stable(sys_rel)));

    a_r9_locked_ignores: assert property (@(posedge clk) disable iff (rst)
        (sys_locked && wr_sys && reg_wdata != KEY) |=> (sys_locked && $stable(sys_rel)));

    a_r10_unlocked_loads: assert property (@(posedge clk) disable iff (rst)
        (!sys_locked && wr_sys) |=>
            (sys_rel == $past(reg_wdata[BUS_W-1]) && sys_locked == $past(reg_wdata[BUS_W-2])));

endmodule

bind brg_irq_ctl brg_irq_ctl_chk #(
    .LOC_W (LOC_W),
    .ERR_W (ERR_W),
    .KEY   (UNLOCK_KEY)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .loc_evt    (loc_evt),
    .err_evt    (err_evt),
    .loc_stat   (loc_stat),
    .loc_mask   (loc_mask),
    .err_stat   (err_stat),
    .sys_rel    (sys_q.rel),
    .sys_locked (sys_q.locked),
    .irq_o      (irq_o)
);

// File: tb/brg_irq_ctl_test.sv
module brg_irq_ctl_test;
    import brg_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [7:0]  loc_evt = 8'h0;
    logic [3:0]  err_evt = 4'h0;
    logic        irq_o;
    logic        down_rst_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    brg_irq_ctl uut (
        .clk        (clk),
        .rst        (rst),
        .reg_en     (reg_en),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .loc_evt    (loc_evt),
        .err_evt    (err_evt),
        .irq_o      (irq_o),
        .down_rst_n (down_rst_n)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1;
        d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] lv, input logic [3:0] ev);
        loc_evt = lv; err_evt = ev;
        step();
        loc_evt = 8'h0; err_evt = 4'h0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        rd(2'd0, d); check("R1 local status", d, 16'h0000);
        rd(2'd1, d); check("R1 mask", d, 16'h0000);
        rd(2'd2, d); check("R1 error status", d, 16'h0000);
        rd(2'd3, d); check("R1 system", d, 16'h4000);
        check("R1 irq", {15'h0, irq_o}, 16'h0);
        check("R1 down_rst_n", {15'h0, down_rst_n}, 16'h0);

        // R2, R5, R3: sweep over each local bit
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            b = 8'h1 << i;
            wr(2'd1, 16'h0000);
            pulse(b, 4'h0);
            rd(2'd0, d); check("R2 single bit set", d, {8'h0, b});
            check("R5 masked off irq", {15'h0, irq_o}, 16'h0);
            wr(2'd1, {8'hA5, b});
            rd(2'd1, d); check("R5 mask readback", d, {8'h0, b});
            check("R5 unmasked irq", {15'h0, irq_o}, 16'h1);
            wr(2'd1, {8'h0, ~b});
            check("R5 other mask irq", {15'h0, irq_o}, 16'h0);
            wr(2'd0, 16'(i * 37));
            rd(2'd0, d); check("R3 any write clears", d, 16'h0000);
        end

        // R2 sticky accumulation, R3 with all-ones data
        pulse(8'h05, 4'h0);
        pulse(8'hA0, 4'h0);
        rd(2'd0, d); check("R2 accumulate", d, 16'h00A5);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, d); check("R3 clear with ones", d, 16'h0000);

        // R4 local: event in same cycle as clear
        pulse(8'h01, 4'h0);
        loc_evt = 8'h80;
        wr(2'd0, 16'h0000);
        loc_evt = 8'h00;
        rd(2'd0, d); check("R4 local set wins", d, 16'h0080);
        wr(2'd0, 16'h0000);

        // R6, R7, R11: all error event patterns
        wr(2'd1, 16'h00FF);
        for (int p = 0; p < 16; p++) begin
            pulse(8'h0, 4'(p));
            rd(2'd2, d); check("R6 error bits", d, 16'(p) << 12);
            check("R11 error no irq", {15'h0, irq_o}, 16'h0);
            wr(2'd2, d);
            rd(2'd2, d); check("R7 write back clears", d, 16'h0000);
        end

        // R7 partial clears
        for (int p = 0; p < 16; p++) begin
            pulse(8'h0, 4'hF);
            wr(2'd2, (16'(p) << 12) | 16'h0FFF);
            rd(2'd2, d); check("R7 partial clear", d, 16'(~p & 4'hF) << 12);
        end
        wr(2'd2, 16'hF000);

        // R4 error: event in same cycle as clear
        pulse(8'h0, 4'hF);
        err_evt = 4'b0100;
        wr(2'd2, 16'hF000);
        err_evt = 4'h0;
        rd(2'd2, d); check("R4 error set wins", d, 16'h4000);
        wr(2'd2, 16'hF000);

        // R9 locked ignores other values
        wr(2'd3, 16'h8000);
        rd(2'd3, d); check("R9 locked release ignored", d, 16'h4000);
        check("R9 down_rst_n held", {15'h0, down_rst_n}, 16'h0);
        wr(2'd3, 16'h0000);
        rd(2'd3, d); check("R9 locked zero ignored", d, 16'h4000);
        for (int b = 0; b < 16; b++) begin
            wr(2'd3, 16'hA05F ^ (16'h1 << b));
            rd(2'd3, d); check("R9 near key ignored", d, 16'h4000);
        end
        // R8 key at another select does not unlock
        wr(2'd1, 16'hA05F);
        wr(2'd2, 16'hA05F);
        rd(2'd3, d); check("R8 key elsewhere", d, 16'h4000);
        wr(2'd1, 16'h0000);

        // R8 key unlocks, release unchanged
        wr(2'd3, 16'hA05F);
        rd(2'd3, d); check("R8 unlock", d, 16'h0000);
        check("R8 down_rst_n kept", {15'h0, down_rst_n}, 16'h0);

        // R10 unlocked writes
        wr(2'd3, 16'h8000);
        rd(2'd3, d); check("R10 release", d, 16'h8000);
        check("R10 down_rst_n high", {15'h0, down_rst_n}, 16'h1);
        wr(2'd3, 16'hA05F);
        rd(2'd3, d); check("R10 key as data", d, 16'h8000);
        wr(2'd3, 16'hC000);
        rd(2'd3, d); check("R10 relock", d, 16'hC000);
        wr(2'd3, 16'h0000);
        rd(2'd3, d); check("R9 relocked ignored", d, 16'hC000);
        check("R9 release held", {15'h0, down_rst_n}, 16'h1);
        wr(2'd3, 16'hA05F);
        rd(2'd3, d); check("R8 unlock keeps release", d, 16'h8000);
        wr(2'd3, 16'h4000);
        rd(2'd3, d); check("R10 assert reset and lock", d, 16'h4000);
        check("R10 down_rst_n low", {15'h0, down_rst_n}, 16'h0);

        finish_run();
    end

endmodule